// File: doc/BRIEF.md
# Guarded Memory Protection Checker

This block screens every memory access a processor core issues against a small set of programmable address regions. No address translation takes place: the access address passes through untouched, and the block only decides whether the access may go ahead and whether it must be reported. Each access is described by its address, its kind (read, write or instruction fetch) and the privilege mode of the core (user or supervisor).

There are two kinds of region. A blocking region stops an access its permissions do not cover: the allow output drops in the same cycle as the request. A watch region lets such an access complete and only reports it. Both kinds raise a fault toward the core. Every region holds a base, a mask and six permission bits, one per combination of mode and access kind. The first fault after the status is cleared is latched in a status record (address, kind, mode and whether it was blocked). The record is held until software clears it through the register write port.

Top module: `mguard_top`

## Requirements
- R1: After reset every region is disabled, `acc_allow` is 1, `flt_block` and `flt_detect` are 0 and `stat_valid` is 0.
- R2: A region hits an access when its enable bit is set and `((acc_addr ^ base) & mask) == 0`. Addresses outside every enabled region are always allowed and raise no fault.
- R3: Region control word: bit 0 enable, bits 1/2/3 grant user read/write/execute, bits 4/5/6 grant supervisor read/write/execute. `acc_type` encoding is 0 read, 1 write, 2 execute, and 3 is reserved. A hitting region never grants type 3. A hit whose granting bit is clear is a violation.
- R4: A violation in a blocking region (regions 0 and 1) drives `acc_allow` to 0 and `flt_block` to 1 in the same cycle as the request.
- R5: A violation in a watch region (regions 2 and 3) leaves `acc_allow` at 1 and raises `flt_detect` in the same cycle.
- R6: When both a blocking and a watch violation occur for one access, only `flt_block` is raised and the status records it as blocked.
- R7: On the clock edge that ends a faulting access while `stat_valid` is 0, the status captures the address, the type, the mode (`stat_super`) and the blocked flag (`stat_block`=1 for a blocking fault). While `stat_valid` is 1, later faults do not change it.
- R8: A write to configuration address all-ones (31 with default parameters) clears `stat_valid`. If a fault arrives in that same cycle, its details are captured instead.
- R9: While `acc_valid` is 0, `acc_allow` is 1, no fault is raised and the status is unchanged.
- R10: A configuration write to address `region*4 + field` sets that region's base (field 0), mask (field 1) or control word (field 2). Writes to field 3, or to a region number that does not exist, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration word address |
| cfg_wdata | input | ADDR_W | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| acc_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| acc_allow | output | 1 | Access may complete |
| flt_block | output | 1 | Blocking violation this cycle |
| flt_detect | output | 1 | Watch-only violation this cycle |
| stat_valid | output | 1 | Status record holds a fault |
| stat_addr | output | ADDR_W | Captured fault address |
| stat_type | output | 2 | Captured access kind |
| stat_super | output | 1 | Captured privilege mode |
| stat_block | output | 1 | Captured fault was blocking |

## Verification
On every cycle the assertions check the relations among the live outputs: a blocking fault always withdraws permission, a watch fault never does, the two fault outputs are never raised together, and an idle cycle is quiet. They also check that a first fault is latched with its address, and that a held record stays frozen until a clear. The region decoding itself can only be shown by the bench's scenarios: which bases and masks hit, which permission bit grants which mode and kind, the refusal of the reserved type, the effect of overlapping regions, ignored configuration writes, and a clear that coincides with a new fault.

// File: rtl/mguard_pkg.sv
package mguard_pkg;

    localparam int PERM_W = 6;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // bit 0 enable, bits 6:1 permissions (user r/w/x, supervisor r/w/x)
    typedef struct packed {
        logic [PERM_W-1:0] perm;
        logic              en;
    } region_ctrl_t;

    function automatic logic perm_granted(logic [PERM_W-1:0] perm,
                                          acc_kind_e kind, logic sup);
        logic [2:0] sel;
        if (kind == ACC_RSVD) return 1'b0;
        sel = {1'b0, kind} + (sup ? 3'd3 : 3'd0);
        return perm[sel];
    endfunction

endpackage

// File: rtl/mguard_cfg.sv
module mguard_cfg
    import mguard_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_REG  = 4,
    parameter int CFG_AW = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output logic [N_REG-1:0][ADDR_W-1:0]   reg_base,
    output logic [N_REG-1:0][ADDR_W-1:0]   reg_mask,
    output region_ctrl_t [N_REG-1:0]       reg_ctrl,
    output logic                           stat_clr
);
    localparam int IDX_W = CFG_AW - 2;

    typedef struct packed {
        logic [N_REG-1:0][ADDR_W-1:0] base;
        logic [N_REG-1:0][ADDR_W-1:0] mask;
        region_ctrl_t [N_REG-1:0]     ctrl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [IDX_W-1:0] wr_idx;
    logic [1:0]       wr_fld;

    assign wr_idx = cfg_addr[CFG_AW-1:2];
    assign wr_fld = cfg_addr[1:0];

    always_comb begin
        cfg_d = cfg_q;
        for (int r = 0; r < N_REG; r++) begin
            if (cfg_we && wr_idx == IDX_W'(r)) begin
                case (wr_fld)
                    2'd0:    cfg_d.base[r] = cfg_wdata;
                    2'd1:    cfg_d.mask[r] = cfg_wdata;
                    2'd2:    cfg_d.ctrl[r] = region_ctrl_t'(cfg_wdata[PERM_W:0]);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign reg_base = cfg_q.base;
    assign reg_mask = cfg_q.mask;
    assign reg_ctrl = cfg_q.ctrl;
    assign stat_clr = cfg_we && (cfg_addr == '1);

endmodule

// File: rtl/mguard_region.sv
module mguard_region
    import mguard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  region_ctrl_t      ctrl,
    input  logic [ADDR_W-1:0] acc_addr,
    input  acc_kind_e         acc_kind,
    input  logic              acc_sup,
    output logic              viol
);
    logic hit;
    logic granted;

    always_comb begin
        hit     = ctrl.en && (((acc_addr ^ base) & mask) == '0);
        granted = perm_granted(ctrl.perm, acc_kind, acc_sup);
        viol    = hit && !granted;
    end

endmodule

// File: rtl/mguard_status.sv
module mguard_status #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              fault_block,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_super,
    input  logic              clr,
    output logic              stat_valid,
    output logic [ADDR_W-1:0] stat_addr,
    output logic [1:0]        stat_type,
    output logic              stat_super,
    output logic              stat_block
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        kind;
        logic              sup;
        logic              block;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.valid = 1'b0;
        if (fault && (!st_q.valid || clr)) begin
            st_d.valid = 1'b1;
            st_d.addr  = acc_addr;
            st_d.kind  = acc_type;
            st_d.sup   = acc_super;
            st_d.block = fault_block;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_valid = st_q.valid;
    assign stat_addr  = st_q.addr;
    assign stat_type  = st_q.kind;
    assign stat_super = st_q.sup;
    assign stat_block = st_q.block;

endmodule

// File: rtl/mguard_top.sv
module mguard_top
    import mguard_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_PREV = 2,
    parameter int N_DET  = 2,
    parameter int CFG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_super,
    output logic              acc_allow,
    output logic              flt_block,
    output logic              flt_detect,
    output logic              stat_valid,
    output logic [ADDR_W-1:0] stat_addr,
    output logic [1:0]        stat_type,
    output logic              stat_super,
    output logic              stat_block
);
    localparam int N_REG = N_PREV + N_DET;

    logic [N_REG-1:0][ADDR_W-1:0] reg_base;
    logic [N_REG-1:0][ADDR_W-1:0] reg_mask;
    region_ctrl_t [N_REG-1:0]     reg_ctrl;
    logic                         stat_clr;

    logic [N_PREV-1:0] prev_viol;
    logic [N_DET-1:0]  det_viol;
    logic              prev_any, det_any;
    acc_kind_e         kind;

    assign kind = acc_kind_e'(acc_type);

    mguard_cfg #(
        .ADDR_W (ADDR_W),
        .N_REG  (N_REG),
        .CFG_AW (CFG_AW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .reg_base  (reg_base),
        .reg_mask  (reg_mask),
        .reg_ctrl  (reg_ctrl),
        .stat_clr  (stat_clr)
    );

    for (genvar g = 0; g < N_REG; g++) begin : g_region
        logic viol;
        mguard_region #(.ADDR_W(ADDR_W)) u_region (
            .base     (reg_base[g]),
            .mask     (reg_mask[g]),
            .ctrl     (reg_ctrl[g]),
            .acc_addr (acc_addr),
            .acc_kind (kind),
            .acc_sup  (acc_super),
            .viol     (viol)
        );
        if (g < N_PREV) begin : g_prev
            assign prev_viol[g] = viol;
        end else begin : g_det
            assign det_viol[g-N_PREV] = viol;
        end
    end

    always_comb begin
        prev_any   = acc_valid && (|prev_viol);
        det_any    = acc_valid && (|det_viol);
        acc_allow  = !prev_any;
        flt_block  = prev_any;
        flt_detect = det_any && !prev_any;
    end

    mguard_status #(.ADDR_W(ADDR_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault       (prev_any || det_any),
        .fault_block (prev_any),
        .acc_addr    (acc_addr),
        .acc_type    (acc_type),
        .acc_super   (acc_super),
        .clr         (stat_clr),
        .stat_valid  (stat_valid),
        .stat_addr   (stat_addr),
        .stat_type   (stat_type),
        .stat_super  (stat_super),
        .stat_block  (stat_block)
    );

endmodule

// File: rtl/mguard_checker.sv
module mguard_checker #(
    parameter int ADDR_W = 32,
    parameter int CFG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_allow,
    input logic              flt_block,
    input logic              flt_detect,
    input logic              stat_valid,
    input logic [ADDR_W-1:0] stat_addr
);
    logic clr_req;
    logic any_flt;

    assign clr_req = cfg_we && (cfg_addr == '1);
    assign any_flt = flt_block || flt_detect;

    AST_BLOCK_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        flt_block |-> !acc_allow);  // R4

    AST_DETECT_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        flt_detect |-> acc_allow);  // R5

    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_block && flt_detect));  // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (acc_allow && !any_flt));  // R9

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_valid && any_flt) |=> (stat_valid && stat_addr == $past(acc_addr)));  // R7

    AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !clr_req) |=> (stat_valid && $stable(stat_addr)));  // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !any_flt) |=> !stat_valid);  // R8

endmodule

bind mguard_top mguard_checker #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_mguard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_allow  (acc_allow),
    .flt_block  (flt_block),
    .flt_detect (flt_detect),
    .stat_valid (stat_valid),
    .stat_addr  (stat_addr)
);

// File: tb/test_mguard_top.sv
module test_mguard_top;
    localparam int CLK_T  = 10;
    localparam int ADDR_W = 32;
    localparam int CFG_AW = 5;
    localparam logic [CFG_AW-1:0] CLR_ADDR = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [1:0]        acc_type = '0;
    logic              acc_super = 1'b0;
    logic              acc_allow, flt_block, flt_detect;
    logic              stat_valid, stat_super, stat_block;
    logic [ADDR_W-1:0] stat_addr;
    logic [1:0]        stat_type;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    mguard_top #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) i_mguard_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_type(acc_type), .acc_super(acc_super), .acc_allow(acc_allow),
        .flt_block(flt_block), .flt_detect(flt_detect), .stat_valid(stat_valid),
        .stat_addr(stat_addr), .stat_type(stat_type), .stat_super(stat_super),
        .stat_block(stat_block)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(logic [CFG_AW-1:0] a, logic [ADDR_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_region(int r, logic [ADDR_W-1:0] b, logic [ADDR_W-1:0] m,
                              logic [ADDR_W-1:0] c);
        cfg_write(CFG_AW'(r*4 + 0), b);
        cfg_write(CFG_AW'(r*4 + 1), m);
        cfg_write(CFG_AW'(r*4 + 2), c);
    endtask

    // drive one access, check the same-cycle outputs, then let one edge pass
    task automatic access(string req, logic [ADDR_W-1:0] a, logic [1:0] t, logic s,
                          logic e_allow, logic e_blk, logic e_det);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_type = t; acc_super = s;
        #1;
        chk(req, "acc_allow", 64'(acc_allow), 64'(e_allow));
        chk(req, "flt_block", 64'(flt_block), 64'(e_blk));
        chk(req, "flt_detect", 64'(flt_detect), 64'(e_det));
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic check_stat(string req, logic v, logic [ADDR_W-1:0] a,
                              logic [1:0] t, logic s, logic b);
        chk(req, "stat_valid", 64'(stat_valid), 64'(v));
        if (v) begin
            chk(req, "stat_addr", 64'(stat_addr), 64'(a));
            chk(req, "stat_type", 64'(stat_type), 64'(t));
            chk(req, "stat_super", 64'(stat_super), 64'(s));
            chk(req, "stat_block", 64'(stat_block), 64'(b));
        end
    endtask

    task automatic clear_stat();
        cfg_write(CLR_ADDR, '0);
        #1;
        chk("R8", "stat_valid after clear", 64'(stat_valid), 64'd0);
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "acc_allow", 64'(acc_allow), 64'd1);
        chk("R1", "flt_block", 64'(flt_block), 64'd0);
        chk("R1", "flt_detect", 64'(flt_detect), 64'd0);
        chk("R1", "stat_valid", 64'(stat_valid), 64'd0);
    endtask

    task automatic t_block();
        // region 0: 0x1xxxxxxx, enable + user read + supervisor rwx
        set_region(0, 32'h1000_0000, 32'hF000_0000, 32'h73);
        access("R2", 32'h2000_0000, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        access("R3", 32'h1234_5678, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        access("R3", 32'h1234_5678, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0);
        access("R4", 32'h1ABC_0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        check_stat("R7", 1'b1, 32'h1ABC_0000, 2'd1, 1'b0, 1'b1);
        access("R4", 32'h1000_0004, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
        check_stat("R7", 1'b1, 32'h1ABC_0000, 2'd1, 1'b0, 1'b1);
        clear_stat();
    endtask

    task automatic t_detect();
        // region 2: 0x8000xxxx, enabled, no permissions
        set_region(2, 32'h8000_0000, 32'hFFFF_0000, 32'h01);
        access("R5", 32'h8000_0010, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
        check_stat("R7", 1'b1, 32'h8000_0010, 2'd2, 1'b1, 1'b0);
        clear_stat();
        access("R2", 32'h8001_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_precedence();
        // region 1: 0x80xxxxxx blocking, overlapping watch region 2
        set_region(1, 32'h8000_0000, 32'hFF00_0000, 32'h01);
        access("R6", 32'h8000_0004, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_stat("R6", 1'b1, 32'h8000_0004, 2'd0, 1'b0, 1'b1);
        clear_stat();
        cfg_write(CFG_AW'(6), 32'h0);   // disable region 1
    endtask

    task automatic t_reserved();
        // region 3: 0x4xxxxxxx watch, every permission granted
        set_region(3, 32'h4000_0000, 32'hF000_0000, 32'h7F);
        access("R3", 32'h4000_0000, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        access("R3", 32'h4000_0000, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        check_stat("R3", 1'b1, 32'h4000_0000, 2'd3, 1'b1, 1'b0);
        clear_stat();
    endtask

    task automatic t_idle();
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 32'h1ABC_0000; acc_type = 2'd1; acc_super = 1'b0;
        #1;
        chk("R9", "acc_allow idle", 64'(acc_allow), 64'd1);
        chk("R9", "flt_block idle", 64'(flt_block), 64'd0);
        @(posedge clk); #1;
        chk("R9", "stat_valid idle", 64'(stat_valid), 64'd0);
    endtask

    task automatic t_cfg_map();
        cfg_write(CFG_AW'(3), 32'h0);            // field 3 of region 0
        cfg_write(CFG_AW'(16), 32'h0);           // region 4 base: no such region
        cfg_write(CFG_AW'(18), 32'h0);           // region 4 ctrl
        access("R10", 32'h1234_5678, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        access("R10", 32'h1ABC_0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        clear_stat();
        cfg_write(CFG_AW'(2), 32'h75);           // user write now, user read off
        access("R10", 32'h1ABC_0000, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        access("R10", 32'h1ABC_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        clear_stat();
    endtask

    task automatic t_clear_collide();
        access("R8", 32'h1000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_stat("R8", 1'b1, 32'h1000_0000, 2'd0, 1'b0, 1'b1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = CLR_ADDR;
        acc_valid = 1'b1; acc_addr = 32'h1000_0008; acc_type = 2'd2; acc_super = 1'b0;
        @(posedge clk); #1;
        cfg_we = 1'b0; acc_valid = 1'b0;
        check_stat("R8", 1'b1, 32'h1000_0008, 2'd2, 1'b0, 1'b1);
        clear_stat();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        #2 rst_n = 1'b1;
        t_reset();
        t_block();
        t_detect();
        t_precedence();
        t_reserved();
        t_idle();
        t_cfg_map();
        t_clear_collide();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_T * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule